// File: doc/BRIEF.md
# Low-Frequency Oscillator Start-Up Sequencer

This block brings a slow external oscillator up safely before its clock is handed to the rest of the chip. Software programs a 32-bit control word on the system clock. The word holds the oscillator enable, the choice between a crystal and an externally driven clock, a start-up delay code, an on-demand mode, a gain setting and some analog trim bits. The trim and gain values are passed straight to the analog macro as output fields.

Once the oscillator is asked to run, the start-up proceeds in two stages. The first stage counts a programmable number of cycles of an always-on low-power clock, and it applies only in crystal mode. The second stage then waits three cycles of the oscillator's own clock. After both stages, the block raises the clock-ready output and, at the same moment, the start signal for the clock-fail monitor.

In on-demand mode the oscillator runs only while a peripheral request is present. Losing the run condition drops both outputs at once, and the next start repeats the whole sequence.

Top module: `osc_start_ctrl`

## Requirements
- R1: After reset the control word reads 0x00200080: gain 0x8 in bits 21:18, on-demand (bit 7) set, and every other bit 0. Bits outside 27:24, 21:16, 11:7, 2 and 1 always read 0.
- R2: A write stores `wdata_i` masked to the implemented bits. The stored value is visible on `rdata_o` from the next cycle. It is also visible on the field outputs: extended control 27:24 on `ext_ctrl_o`, gain 21:18 on `gain_o`, boost bit 17, servo enable bit 16, crystal select bit 2, enable bit 1.
- R3: While the stored enable bit (bit 1) is 1, a write leaves the gain field unchanged and updates all other fields. This includes a write that clears enable.
- R4: In crystal mode (bit 2 = 1), the start-up code in bits 11:8 selects the first-stage length in low-power clock cycles: 0→1, 1→16, 2→32, 3→2048, 4→4096, 5→8192, 6→16384, 7→32768, 8→65536, 9→131072, 10→262144. Clock-ready never rises before that many low-power cycles have elapsed.
- R5: Clock-ready rises only after 3 further oscillator clock cycles following the end of the first stage.
- R6: `fail_mon_start_o` equals `clk_ready_o` at all times.
- R7: In external-clock mode (bit 2 = 0), the first stage is skipped, and clock-ready follows only the 3-cycle oscillator stage, whatever the start-up code is.
- R8: `osc_run_o` is 1 exactly when enable is 1 and either on-demand (bit 7) is 0 or `periph_req_i` is 1. While it is 0, clock-ready stays 0.
- R9: Clearing enable, or dropping the request in on-demand mode, deasserts clock-ready and fail-monitor start in the same cycle. A later restart runs both stages again from zero.
- R10: Start-up codes 11 to 15 behave as code 10 (262144 low-power cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for the control word |
| rst_ni | input | 1 | Asynchronous active-low reset, all domains |
| lp_clk_i | input | 1 | Always-on low-power clock for the first stage |
| osc_clk_i | input | 1 | Clock from the oscillator being started |
| wr_en_i | input | 1 | Write strobe for the control word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Current control word |
| periph_req_i | input | 1 | Peripheral clock request for on-demand mode |
| osc_run_o | output | 1 | Run command to the analog oscillator |
| xtal_sel_o | output | 1 | Crystal (1) or external clock (0) pad mode |
| gain_o | output | 4 | Gain setting to the analog macro |
| boost_o | output | 1 | Gain boost control |
| servo_en_o | output | 1 | Servo loop enable |
| ext_ctrl_o | output | 4 | Extended analog control bits |
| clk_ready_o | output | 1 | Oscillator clock released for internal use |
| fail_mon_start_o | output | 1 | Starts clock-fail monitoring |

## Verification
The hardest case to reach is a restart that must not reuse stale completion state. The oscillator has to be fully released, then stopped through the peripheral request rather than the enable bit, and then restarted; only after that can the latency be measured again. The bench drives that path directly and requires the second latency to fall inside the same window as a cold start.

The longest start-up codes, including the reserved ones, are reached by running the low-power clock much faster than the system clock. This brings 262144 cycles within reach, and the release time is checked against a window computed for each code.

// File: rtl/osc_start_pkg.sv
`timescale 1ns/1ps
package osc_start_pkg;
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned FIELD_W  = 4;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 32'h0020_0080;
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 32'h0F3F_0F86;
  localparam int unsigned EN_BIT    = 1;
  localparam int unsigned XTAL_BIT  = 2;
  localparam int unsigned OD_BIT    = 7;
  localparam int unsigned SU_LSB    = 8;
  localparam int unsigned SERVO_BIT = 16;
  localparam int unsigned BOOST_BIT = 17;
  localparam int unsigned GAIN_LSB  = 18;
  localparam int unsigned XC_LSB    = 24;

  // low-power cycles per start-up code; reserved codes take the longest
  function automatic int unsigned startup_cycles(input logic [FIELD_W-1:0] code);
    if (code == 4'd0)      return 1;
    else if (code == 4'd1) return 16;
    else if (code == 4'd2) return 32;
    else if (code <= 4'd10) return 32'd2048 << (code - 4'd3);
    else                   return 32'd262144;
  endfunction
endpackage

// File: rtl/osc_sync2.sv
`timescale 1ns/1ps
module osc_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s0_q, s1_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= '0;
      s1_q <= '0;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
    end
  end
  assign q_o = s1_q;
endmodule

// File: rtl/osc_ctrl_regs.sv
`timescale 1ns/1ps
module osc_ctrl_regs
  import osc_start_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              periph_req_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              run_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) begin
      ctrl_d = wdata_i & CTRL_WMASK;
      if (ctrl_q[EN_BIT])
        ctrl_d[GAIN_LSB +: FIELD_W] = ctrl_q[GAIN_LSB +: FIELD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RESET;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
  assign run_o  = ctrl_q[EN_BIT] & (~ctrl_q[OD_BIT] | periph_req_i);

  assert_gain_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctrl_q[EN_BIT]) |=> $stable(ctrl_q[GAIN_LSB +: FIELD_W]));
  assert_enable_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ctrl_q[EN_BIT] == $past(wdata_i[EN_BIT])));
endmodule

// File: rtl/osc_lp_timer.sv
`timescale 1ns/1ps
module osc_lp_timer
  import osc_start_pkg::*;
#(
  parameter int unsigned LP_CNT_W = 18
) (
  input  logic               lp_clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               xtal_i,
  input  logic [FIELD_W-1:0] code_i,
  output logic               done_o
);
  logic [1:0]          lvl_s;
  logic                run_s, xtal_s;
  logic [LP_CNT_W-1:0] cnt_q, lim;
  logic                done_q;

  osc_sync2 #(.W(2)) i_sync (
    .clk_i(lp_clk_i), .rst_ni(rst_ni), .d_i({run_i, xtal_i}), .q_o(lvl_s)
  );
  assign run_s  = lvl_s[1];
  assign xtal_s = lvl_s[0];
  // code is quasi-static while the oscillator runs
  assign lim = LP_CNT_W'(startup_cycles(code_i) - 1);

  always_ff @(posedge lp_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!run_s) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!xtal_s) begin
      done_q <= 1'b1;
    end else if (!done_q) begin
      if (cnt_q >= lim) done_q <= 1'b1;
      else              cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;

  assert_done_needs_run_R9: assert property (@(posedge lp_clk_i) disable iff (!rst_ni)
    done_q |-> $past(run_s));
endmodule

// File: rtl/osc_release_stage.sv
`timescale 1ns/1ps
module osc_release_stage #(
  parameter int unsigned OSC_WAIT = 3
) (
  input  logic osc_clk_i,
  input  logic rst_ni,
  input  logic lp_done_i,
  output logic rel_o
);
  localparam int unsigned OW_W = (OSC_WAIT > 1) ? $clog2(OSC_WAIT) : 1;

  logic            done_s, rel_q;
  logic [OW_W-1:0] cnt_q;

  osc_sync2 #(.W(1)) i_sync (
    .clk_i(osc_clk_i), .rst_ni(rst_ni), .d_i(lp_done_i), .q_o(done_s)
  );

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!done_s) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q) begin
      if (cnt_q == OW_W'(OSC_WAIT - 1)) rel_q <= 1'b1;
      else                              cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rel_o = rel_q;

  assert_release_wait_R5: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    $rose(rel_q) |-> ($past(done_s, 1) && $past(done_s, 2) && $past(done_s, 3)));
  assert_release_drop_R9: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    !done_s |=> !rel_q);
endmodule

// File: rtl/osc_start_ctrl.sv
`timescale 1ns/1ps
module osc_start_ctrl
  import osc_start_pkg::*;
#(
  parameter int unsigned LP_CNT_W = 18,
  parameter int unsigned OSC_WAIT = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lp_clk_i,
  input  logic        osc_clk_i,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        periph_req_i,
  output logic        osc_run_o,
  output logic        xtal_sel_o,
  output logic [3:0]  gain_o,
  output logic        boost_o,
  output logic        servo_en_o,
  output logic [3:0]  ext_ctrl_o,
  output logic        clk_ready_o,
  output logic        fail_mon_start_o
);
  logic [CTRL_W-1:0] ctrl;
  logic              run, lp_done, rel;

  osc_ctrl_regs i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .periph_req_i(periph_req_i), .ctrl_o(ctrl), .run_o(run)
  );

  osc_lp_timer #(.LP_CNT_W(LP_CNT_W)) i_lp_timer (
    .lp_clk_i(lp_clk_i), .rst_ni(rst_ni), .run_i(run), .xtal_i(ctrl[XTAL_BIT]),
    .code_i(ctrl[SU_LSB +: FIELD_W]), .done_o(lp_done)
  );

  osc_release_stage #(.OSC_WAIT(OSC_WAIT)) i_release (
    .osc_clk_i(osc_clk_i), .rst_ni(rst_ni), .lp_done_i(lp_done), .rel_o(rel)
  );

  assign rdata_o          = ctrl;
  assign osc_run_o        = run;
  assign xtal_sel_o       = ctrl[XTAL_BIT];
  assign gain_o           = ctrl[GAIN_LSB +: FIELD_W];
  assign boost_o          = ctrl[BOOST_BIT];
  assign servo_en_o       = ctrl[SERVO_BIT];
  assign ext_ctrl_o       = ctrl[XC_LSB +: FIELD_W];
  // run gating makes stop immediate, independent of the slow domains
  assign clk_ready_o      = rel & run;
  assign fail_mon_start_o = rel & run;
endmodule

// File: tb/test_osc_start_ctrl.sv
`timescale 1ns/1ps
module test_osc_start_ctrl;
  logic        clk = 0, lp_clk = 0, osc_clk = 0, rst_n = 0;
  logic        wr_en = 0, req = 0;
  logic [31:0] wdata = '0, rdata;
  logic        run, xtal, boost, servo, ready, fmon;
  logic [3:0]  gain, xc;
  int          n_cmp = 0, n_bad = 0, cyc_total = 0;
  logic [31:0] model = 32'h0020_0080;
  localparam logic [31:0] MASK = 32'h0F3F_0F86;

  always #5   clk = ~clk;
  always #0.5 lp_clk = ~lp_clk;
  always #15  osc_clk = ~osc_clk;

  osc_start_ctrl i_osc_start_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .lp_clk_i(lp_clk), .osc_clk_i(osc_clk),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .periph_req_i(req),
    .osc_run_o(run), .xtal_sel_o(xtal), .gain_o(gain), .boost_o(boost),
    .servo_en_o(servo), .ext_ctrl_o(xc), .clk_ready_o(ready), .fail_mon_start_o(fmon)
  );

  function automatic int lp_cycles(input logic [3:0] c);
    case (c)
      4'd0: return 1;      4'd1: return 16;     4'd2: return 32;
      4'd3: return 2048;   4'd4: return 4096;   4'd5: return 8192;
      4'd6: return 16384;  4'd7: return 32768;  4'd8: return 65536;
      4'd9: return 131072; default: return 262144;
    endcase
  endfunction

  function automatic logic [31:0] cfg(input logic en, input logic xt, input logic od,
                                      input logic [3:0] code, input logic [3:0] g);
    logic [31:0] v = '0;
    v[1] = en; v[2] = xt; v[7] = od; v[11:8] = code; v[21:18] = g;
    return v;
  endfunction

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    logic [31:0] nx;
    @(negedge clk);
    wr_en = 1; wdata = v;
    @(negedge clk);
    wr_en = 0;
    nx = v & MASK;
    if (model[1]) nx[21:18] = model[21:18];
    model = nx;
  endtask

  task automatic settle();
    wr(model & ~32'h2);
    repeat (60) @(negedge clk);
  endtask

  task automatic measure(output int c);
    c = 0;
    while (!ready && c < 40000) begin
      if (fmon !== ready) check(0, "R6", {31'd0, fmon}, {31'd0, ready});
      @(negedge clk); c++;
    end
  endtask

  task automatic start_check(input logic xt, input logic [3:0] code, input string r);
    int c, n, ns;
    wr(cfg(1, xt, 0, code, model[21:18]));
    measure(c);
    ns = c * 10;
    n = xt ? lp_cycles(code) : 0;
    check(ns >= n + 60 && ns <= n + 400, r, ns, n);
    check(fmon == 1'b1, "R6", {31'd0, fmon}, 1);
  endtask

  initial begin
    while (1) begin
      @(posedge clk); cyc_total++;
      if (cyc_total > 190000) begin
        check(0, "watchdog", cyc_total, 190000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int c;
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(rdata == 32'h0020_0080, "R1", rdata, 32'h0020_0080);
    check(ready == 0 && run == 0, "R1", {ready, run}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(rdata == 32'h0020_0080 && gain == 4'h8, "R1", rdata, 32'h0020_0080);

    // random writes with enable low
    for (int i = 0; i < 20; i++) begin
      v = $urandom() & ~32'h2;
      wr(v);
      check(rdata == model, "R2", rdata, model);
      check({xc, gain, boost, servo, xtal} == {model[27:24], model[21:18], model[17], model[16], model[2]},
            "R2", {xc, gain, boost, servo, xtal}, {model[27:24], model[21:18], model[17], model[16], model[2]});
      check((rdata & ~MASK) == 0, "R1", rdata & ~MASK, 0);
    end

    // gain lock: external mode keeps the slow counter idle
    wr(cfg(0, 0, 0, 0, 4'h5));
    wr(cfg(1, 0, 0, 0, 4'h5));
    check(gain == 4'h5, "R2", gain, 5);
    for (int i = 0; i < 10; i++) begin
      v = ($urandom() | 32'h2) & ~32'h4;
      wr(v);
      check(gain == 4'h5, "R3", gain, 5);
      check(rdata == model, "R3", rdata, model);
    end
    wr(cfg(0, 0, 0, 0, 4'h9));
    check(gain == 4'h5, "R3", gain, 5);
    wr(cfg(0, 0, 0, 0, 4'h9));
    check(gain == 4'h9, "R3", gain, 9);
    repeat (60) @(negedge clk);

    // external clock: code ignored
    start_check(0, 4'hA, "R7");
    settle();
    start_check(0, 4'h0, "R7");
    settle();

    // crystal codes
    start_check(1, 4'h0, "R4"); settle();
    start_check(1, 4'h1, "R4"); settle();
    start_check(1, 4'h2, "R5"); settle();
    start_check(1, 4'h3, "R4"); settle();
    start_check(1, 4'h4, "R4"); settle();
    start_check(1, 4'h5, "R4"); settle();
    start_check(1, 4'hA, "R4"); settle();
    start_check(1, 4'hC, "R10"); settle();

    // on-demand
    req = 0;
    wr(cfg(1, 1, 1, 4'h0, model[21:18]));
    check(run == 0, "R8", run, 0);
    repeat (200) @(negedge clk);
    check(ready == 0 && fmon == 0, "R8", {ready, fmon}, 0);
    req = 1;
    #1 check(run == 1, "R8", run, 1);
    measure(c);
    check(c * 10 >= 61 && c * 10 <= 401, "R8", c * 10, 1);
    // drop request: immediate stop
    req = 0;
    #1 check(ready == 0 && fmon == 0, "R9", {ready, fmon}, 0);
    check(run == 0, "R8", run, 0);
    repeat (60) @(negedge clk);
    wr(cfg(1, 1, 1, 4'h2, model[21:18]));
    repeat (60) @(negedge clk);
    req = 1;
    measure(c);
    check(c * 10 >= 92 && c * 10 <= 432, "R9", c * 10, 32);
    // clear enable: stop on the write edge
    wr(cfg(0, 1, 1, 4'h2, model[21:18]));
    check(ready == 0 && fmon == 0, "R9", {ready, fmon}, 0);
    req = 0;
    repeat (60) @(negedge clk);
    // on-demand clear: run without request
    wr(cfg(1, 0, 0, 4'h0, model[21:18]));
    check(run == 1, "R8", run, 1);
    measure(c);
    check(ready == 1, "R8", ready, 1);
    settle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule